// File: doc/BRIEF.md
# Identifier-Tagged Address Translation Buffer

A small fully associative buffer that caches translations from a guest virtual page directly to a host physical page. Every cached entry carries the virtual processor identifier that was current when the entry was written. Identifier zero belongs to the hypervisor, and each guest virtual processor uses a distinct non-zero value. Because a lookup compares the identifier as well as the page number, translations from several guests and from the hypervisor can sit in the buffer together. Changing the current identifier therefore needs no flush.

The lookup is purely combinational. A virtual address and the current identifier go in, and a hit flag and a host physical address come out in the same cycle. A page walker fills the buffer on a miss through a fill port, and the fill is tagged with the current identifier. Software-driven maintenance uses an invalidate port. That port either drops every entry of one identifier or clears the whole buffer in a single cycle.

Top module: `vtb_top`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: A lookup hits only when a valid entry holds both the same virtual page number (address bits above the 12-bit page offset) and the same identifier as `cur_id_i`. On a hit, `lk_paddr_o` is the stored physical page number concatenated with the lookup's page offset, in the same cycle.
- R3: A fill is tagged with `cur_id_i` of the fill cycle and can be looked up from the next cycle on.
- R4: Changing `cur_id_i` invalidates nothing. An entry of one identifier hits again once that identifier is current again.
- R5: An entry tagged with the hypervisor identifier 0 and a guest entry with the same virtual page coexist, and each returns its own physical page.
- R6: A fill that matches no surviving entry goes to the lowest-indexed invalid entry. When all entries are valid, it goes to a round-robin victim. The victim pointer starts at entry 0 after reset and advances by one, wrapping after the last entry, only on such an eviction.
- R7: A fill whose virtual page and identifier match a valid entry overwrites that entry. It does not create a second copy and does not consume a slot.
- R8: An invalidate by identifier clears every entry with that tag in one cycle and leaves all other entries intact.
- R9: A global invalidate clears all entries in one cycle.
- R10: When an invalidate and a fill share a cycle, the invalidate is applied first and the fill afterwards, so the filled translation survives. An entry cleared by the invalidate counts as free for the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cur_id_i | input | ID_W (6) | Current virtual processor identifier, 0 = hypervisor |
| lk_vaddr_i | input | VA_W (32) | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | PA_W (40) | Translated host physical address, valid when hit |
| fill_i | input | 1 | Write a translation tagged with cur_id_i |
| fill_vpn_i | input | VA_W-12 (20) | Virtual page number to fill |
| fill_ppn_i | input | PA_W-12 (28) | Physical page number to fill |
| inv_id_i | input | 1 | Invalidate all entries tagged with inv_tag_i |
| inv_tag_i | input | ID_W (6) | Identifier to invalidate |
| inv_all_i | input | 1 | Invalidate every entry |

## Verification
Lookup results are combinational, so the bench drives each vector just after a falling edge and samples the hit flag and the address one nanosecond later, before the next rising edge. Fills and invalidates take effect at that rising edge. A reference model, updated after the edge in the order of R10, supplies the expected result for the next vector, which is how a fill becomes visible one cycle after it is applied. Directed sequences cover the identifier switch, hypervisor coexistence, duplicate fill, round-robin eviction and the combined invalidate-plus-fill case. A seeded random phase then mixes all commands over a small page pool so that hits, aliases and evictions are frequent.

// File: rtl/vtb_pkg.sv
package vtb_pkg;
  // where a fill lands
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_DUP  = 2'd1,
    SLOT_FREE = 2'd2,
    SLOT_RR   = 2'd3
  } slot_src_e;
endpackage

// File: rtl/vtb_entry.sv
module vtb_entry #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 28,
  parameter int ID_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             inv_all_i,
  input  logic             inv_id_i,
  input  logic [ID_W-1:0]  inv_tag_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [ID_W-1:0]  lk_id_i,
  output logic             valid_o,
  output logic             keep_o,
  output logic             lk_hit_o,
  output logic             dup_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic             valid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [ID_W-1:0]  id_q;
  logic [PPN_W-1:0] ppn_q;
  logic             clr;

  assign clr      = inv_all_i | (inv_id_i & (id_q == inv_tag_i));
  assign keep_o   = valid_q & ~clr;
  assign valid_o  = valid_q;
  assign lk_hit_o = valid_q & (vpn_q == lk_vpn_i) & (id_q == lk_id_i);
  assign dup_o    = keep_o & (vpn_q == wr_vpn_i) & (id_q == wr_id_i);
  assign ppn_o    = ppn_q;

  // fill is applied after invalidate, so it wins on its own slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      id_q    <= '0;
      ppn_q   <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      vpn_q   <= wr_vpn_i;
      id_q    <= wr_id_i;
      ppn_q   <= wr_ppn_i;
    end else if (clr) begin
      valid_q <= 1'b0;
    end
  end

  a_r3_write_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_q && (id_q == $past(wr_id_i)) && (vpn_q == $past(wr_vpn_i)));

  a_r8_clear_drops_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_id_i && valid_q && (id_q == inv_tag_i) && !wr_i) |=> !valid_q);

  a_r4_holds_without_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inv_all_i && !inv_id_i) |=> $stable(valid_q) && $stable(ppn_q));
endmodule

// File: rtl/vtb_victim.sv
module vtb_victim
  import vtb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fill_i,
  input  logic [N-1:0] keep_i,
  input  logic [N-1:0] dup_i,
  output logic [N-1:0] sel_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  slot_src_e        src;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!keep_i[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (!fill_i)         src = SLOT_NONE;
    else if (|dup_i)     src = SLOT_DUP;
    else if (!(&keep_i)) src = SLOT_FREE;
    else                 src = SLOT_RR;
  end

  always_comb begin
    sel_o = '0;
    unique case (src)
      SLOT_DUP:  sel_o = dup_i;
      SLOT_FREE: sel_o[free_idx] = 1'b1;
      SLOT_RR:   sel_o[rr_q] = 1'b1;
      default:   sel_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (src == SLOT_RR) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  a_r7_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> $countones(sel_o) == 1);

  a_r7_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |-> sel_o == '0);

  a_r6_rr_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(&keep_i)) |=> $stable(rr_q));

  a_r6_free_slot_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && dup_i == '0 && !(&keep_i)) |-> (sel_o & keep_i) == '0);
endmodule

// File: rtl/vtb_hit_mux.sv
module vtb_hit_mux #(
  parameter int N     = 8,
  parameter int PPN_W = 28
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          hit_i,
  input  logic [N-1:0][PPN_W-1:0] ppn_i,
  output logic                  hit_o,
  output logic [PPN_W-1:0]      ppn_o
);
  always_comb begin
    ppn_o = '0;
    for (int i = 0; i < N; i++) begin
      ppn_o = ppn_o | (ppn_i[i] & {PPN_W{hit_i[i]}});
    end
  end

  assign hit_o = |hit_i;

  // duplicate suppression must keep matches unique
  a_r7_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_i));
endmodule

// File: rtl/vtb_top.sv
module vtb_top #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 40,
  parameter int OFF_W = 12,
  parameter int ID_W  = 6,
  parameter int N     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ID_W-1:0]       cur_id_i,
  input  logic [VA_W-1:0]       lk_vaddr_i,
  output logic                  lk_hit_o,
  output logic [PA_W-1:0]       lk_paddr_o,
  input  logic                  fill_i,
  input  logic [VA_W-OFF_W-1:0] fill_vpn_i,
  input  logic [PA_W-OFF_W-1:0] fill_ppn_i,
  input  logic                  inv_id_i,
  input  logic [ID_W-1:0]       inv_tag_i,
  input  logic                  inv_all_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [N-1:0]             valid_v;
  logic [N-1:0]             keep_v;
  logic [N-1:0]             hit_v;
  logic [N-1:0]             dup_v;
  logic [N-1:0]             sel_v;
  logic [N-1:0][PPN_W-1:0]  ppn_v;
  logic [PPN_W-1:0]         hit_ppn;
  logic [VPN_W-1:0]         lk_vpn;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFF_W];

  for (genvar g = 0; g < N; g++) begin : g_ent
    vtb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ID_W(ID_W)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (sel_v[g]),
      .wr_vpn_i  (fill_vpn_i),
      .wr_id_i   (cur_id_i),
      .wr_ppn_i  (fill_ppn_i),
      .inv_all_i (inv_all_i),
      .inv_id_i  (inv_id_i),
      .inv_tag_i (inv_tag_i),
      .lk_vpn_i  (lk_vpn),
      .lk_id_i   (cur_id_i),
      .valid_o   (valid_v[g]),
      .keep_o    (keep_v[g]),
      .lk_hit_o  (hit_v[g]),
      .dup_o     (dup_v[g]),
      .ppn_o     (ppn_v[g])
    );
  end

  vtb_victim #(.N(N)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fill_i (fill_i),
    .keep_i (keep_v),
    .dup_i  (dup_v),
    .sel_o  (sel_v)
  );

  vtb_hit_mux #(.N(N), .PPN_W(PPN_W)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_v),
    .ppn_i  (ppn_v),
    .hit_o  (lk_hit_o),
    .ppn_o  (hit_ppn)
  );

  assign lk_paddr_o = {hit_ppn, lk_vaddr_i[OFF_W-1:0]};

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !fill_i) |=> valid_v == '0);

  a_r10_fill_survives_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && (inv_all_i || inv_id_i)) |=> $countones(valid_v) >= 1);

  a_r9_flush_then_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !fill_i) |=> !lk_hit_o);
endmodule

// File: tb/tb_vtb_top.sv
`timescale 1ns/1ps
module tb_vtb_top;
  localparam int VA_W = 32, PA_W = 40, OFF_W = 12, ID_W = 6, N = 8;
  localparam int VPN_W = VA_W - OFF_W, PPN_W = PA_W - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ID_W-1:0]  cur_id = '0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic             hit;
  logic [PA_W-1:0]  paddr;
  logic             fill = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             inv_id = 1'b0;
  logic [ID_W-1:0]  inv_tag = '0;
  logic             inv_all = 1'b0;

  always #4 clk = ~clk;

  vtb_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cur_id_i(cur_id), .lk_vaddr_i(lk_vaddr),
    .lk_hit_o(hit), .lk_paddr_o(paddr), .fill_i(fill), .fill_vpn_i(fill_vpn),
    .fill_ppn_i(fill_ppn), .inv_id_i(inv_id), .inv_tag_i(inv_tag), .inv_all_i(inv_all)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  bit               m_vld [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [ID_W-1:0]  m_id  [N];
  logic [PPN_W-1:0] m_ppn [N];
  int               m_rr = 0;

  function automatic bit m_hit(input logic [VPN_W-1:0] v, input logic [ID_W-1:0] id);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == v && m_id[i] == id) return 1;
    return 0;
  endfunction

  function automatic logic [PA_W-1:0] m_pa(input logic [VA_W-1:0] va, input logic [ID_W-1:0] id);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_vpn[i] == va[VA_W-1:OFF_W] && m_id[i] == id)
        return {m_ppn[i], va[OFF_W-1:0]};
    return '0;
  endfunction

  task automatic m_update();
    int idx;
    for (int i = 0; i < N; i++)
      if (inv_all || (inv_id && m_id[i] == inv_tag)) m_vld[i] = 0;
    if (fill) begin
      idx = -1;
      for (int i = 0; i < N; i++)
        if (m_vld[i] && m_vpn[i] == fill_vpn && m_id[i] == cur_id) idx = i;
      if (idx < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) idx = i;
      if (idx < 0) begin
        idx = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_vld[idx] = 1; m_vpn[idx] = fill_vpn; m_id[idx] = cur_id; m_ppn[idx] = fill_ppn;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive, sample lookup, clock, update model
  task automatic step(input string tag, input logic [VPN_W-1:0] v, input logic [ID_W-1:0] id,
                      input bit f, input logic [VPN_W-1:0] fv, input logic [PPN_W-1:0] fp,
                      input bit ii, input logic [ID_W-1:0] it, input bit ia);
    logic [VA_W-1:0] va;
    va = {v, 12'(($urandom() % 4096))};
    @(negedge clk);
    cur_id = id; lk_vaddr = va; fill = f; fill_vpn = fv; fill_ppn = fp;
    inv_id = ii; inv_tag = it; inv_all = ia;
    #1;
    check({tag, " hit"}, 64'(hit), 64'(m_hit(v, id)));
    if (m_hit(v, id)) check({tag, " paddr"}, 64'(paddr), 64'(m_pa(va, id)));
    @(posedge clk);
    m_update();
    #1;
    fill = 0; inv_id = 0; inv_all = 0;
  endtask

  task automatic look(input string tag, input logic [VPN_W-1:0] v, input logic [ID_W-1:0] id);
    step(tag, v, id, 0, '0, '0, 0, '0, 0);
  endtask

  task automatic expect_hit(input string tag, input logic [VPN_W-1:0] v,
                            input logic [ID_W-1:0] id, input bit eh, input logic [PPN_W-1:0] ep);
    @(negedge clk);
    cur_id = id; lk_vaddr = {v, 12'h5a3};
    #1;
    check({tag, " direct hit"}, 64'(hit), 64'(eh));
    if (eh) check({tag, " direct paddr"}, 64'(paddr), 64'({ep, 12'h5a3}));
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_vpn[i] = '0; m_id[i] = '0; m_ppn[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) look("R1", VPN_W'(i), ID_W'(i));
    expect_hit("R1", 20'h00010, 6'd1, 0, '0);

    // R3 fill tagged with current id, R2 match on id and page
    step("R3", 20'h00010, 6'd1, 1, 20'h00010, 28'h000000a, 0, '0, 0);
    expect_hit("R3", 20'h00010, 6'd1, 1, 28'h000000a);
    expect_hit("R2", 20'h00010, 6'd2, 0, '0);
    expect_hit("R2", 20'h00011, 6'd1, 0, '0);

    // R5 hypervisor entry alongside guest entry
    step("R5", 20'h00010, 6'd0, 1, 20'h00010, 28'h000000b, 0, '0, 0);
    expect_hit("R5", 20'h00010, 6'd0, 1, 28'h000000b);
    expect_hit("R5", 20'h00010, 6'd1, 1, 28'h000000a);

    // R4 id switching keeps entries
    look("R4", 20'h00010, 6'd2);
    look("R4", 20'h00010, 6'd0);
    expect_hit("R4", 20'h00010, 6'd1, 1, 28'h000000a);

    // R7 duplicate fill overwrites
    step("R7", 20'h00010, 6'd1, 1, 20'h00010, 28'h000000c, 0, '0, 0);
    expect_hit("R7", 20'h00010, 6'd1, 1, 28'h000000c);
    for (int i = 0; i < 6; i++)
      step("R7", 20'h00020, 6'd3, 1, VPN_W'(32'h20 + i), PPN_W'(32'h100 + i), 0, '0, 0);
    expect_hit("R7", 20'h00010, 6'd1, 1, 28'h000000c);
    expect_hit("R7", 20'h00010, 6'd0, 1, 28'h000000b);

    // R6 full buffer evicts entry 0 then entry 1
    step("R6", 20'h00030, 6'd3, 1, 20'h00030, 28'h0000200, 0, '0, 0);
    expect_hit("R6", 20'h00010, 6'd1, 0, '0);
    expect_hit("R6", 20'h00010, 6'd0, 1, 28'h000000b);
    step("R6", 20'h00031, 6'd3, 1, 20'h00031, 28'h0000201, 0, '0, 0);
    expect_hit("R6", 20'h00010, 6'd0, 0, '0);
    expect_hit("R6", 20'h00030, 6'd3, 1, 28'h0000200);

    // R8 invalidate one identifier
    step("R8", 20'h00040, 6'd4, 1, 20'h00040, 28'h0000300, 0, '0, 0);
    step("R8", 20'h00040, 6'd4, 0, '0, '0, 1, 6'd3, 0);
    expect_hit("R8", 20'h00030, 6'd3, 0, '0);
    expect_hit("R8", 20'h00020, 6'd3, 0, '0);
    expect_hit("R8", 20'h00040, 6'd4, 1, 28'h0000300);

    // R10 fill with same-id invalidate survives
    step("R10", 20'h00040, 6'd4, 1, 20'h00040, 28'h0000301, 1, 6'd4, 0);
    expect_hit("R10", 20'h00040, 6'd4, 1, 28'h0000301);

    // R9 global invalidate, R10 combined with fill
    step("R9", 20'h00050, 6'd5, 1, 20'h00050, 28'h0000400, 0, '0, 0);
    step("R9", 20'h00050, 6'd5, 0, '0, '0, 0, '0, 1);
    expect_hit("R9", 20'h00050, 6'd5, 0, '0);
    expect_hit("R9", 20'h00040, 6'd4, 0, '0);
    step("R10", 20'h00060, 6'd6, 1, 20'h00061, 28'h0000500, 0, '0, 0);
    step("R10", 20'h00061, 6'd6, 1, 20'h00062, 28'h0000501, 0, '0, 1);
    expect_hit("R10", 20'h00062, 6'd6, 1, 28'h0000501);
    expect_hit("R10", 20'h00061, 6'd6, 0, '0);

    // random mix over a small page and id pool
    for (int k = 0; k < 5000; k++) begin
      automatic int r = $urandom_range(0, 99);
      step("RND R2-model", VPN_W'($urandom_range(0, 11)), ID_W'($urandom_range(0, 3)),
           r < 45, VPN_W'($urandom_range(0, 11)), PPN_W'($urandom()),
           (r % 10) == 3, ID_W'($urandom_range(0, 3)), r == 97);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule